// File: doc/BRIEF.md
# XOR-Coded Banked Multiport Register File

This block is a register file that its users see as one array with many independent read and write ports. The default is 128 entries, 8 read ports and 4 write ports. Inside, the registers sit in two data banks: even register numbers go to bank A and odd ones go to bank B. Each bank has only half of the logical ports. A third, coded bank keeps the XOR of the two data banks for every row.

Every port uses a valid/ready handshake. Within one cycle, a combinational allocator hands the physical bank ports to requests. Writes are placed first, then reads, and lower port numbers win at each step. A read whose home bank has no read port left is rebuilt from the other data bank and the coded bank. A request that cannot be placed sees ready low and is simply presented again. Reads are combinational: data is valid in the same cycle as the handshake. Writes take effect at the next rising clock edge.

Top module: `crf_top`

## Requirements
- R1: A synchronous reset clears every register in the two data banks, and every coded row, to zero. A read after reset returns 0.
- R2: Register r lives in bank r[0] at row r>>1. A granted read returns the value left by the most recent granted write to r.
- R3: A write to bank X is granted only if two resources are free: one of the BWR write ports of bank X (default 2), and one read port of the other data bank. The other-bank port fetches the value needed for the coded row. Writes are placed before reads, in ascending port order.
- R4: When several write ports present the same register in one cycle, only the lowest-numbered one is granted. The others see ready low.
- R5: Reads are placed in ascending port order. A read takes a free read port of its home bank first. Each data bank has BRD read ports (default 4).
- R6: A read whose home bank has no free read port is granted only if a read port of the other data bank and one of the CRD coded-bank read ports (default 4) are free. It returns other_bank[row] XOR coded[row], which equals the stored value. The total number of granted reads plus granted writes never exceeds 2*BRD.
- R7: A read of a register that is written in the same cycle returns the old value. This holds for direct reads and rebuilt reads alike.
- R8: After every clock edge, every coded row equals bankA[row] XOR bankB[row].
- R9: When both banks write the same row in one cycle, the coded row takes the XOR of the two new values. Later rebuilt reads of that row are correct.
- R10: A write that is not granted leaves the register file unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_valid | input | NRD | Read request per port |
| rd_addr | input | NRD*AW | Register number per read port, port i at bits [i*AW +: AW] |
| rd_ready | output | NRD | Read granted this cycle |
| rd_data | output | NRD*DW | Read data per port, valid when valid and ready are both high |
| wr_valid | input | NWR | Write request per port |
| wr_addr | input | NWR*AW | Register number per write port |
| wr_data | input | NWR*DW | Write data per port |
| wr_ready | output | NWR | Write granted; the register updates at the next edge |

## Verification
The bench builds the block with 16 registers of 8 bits and keeps the default 8-read, 4-write port set with 4 read and 2 write ports per bank. With that size, an address sweep writes and reads back every register several times. The random traffic also lands on the same row in both banks, and on duplicate write addresses, very often. The full port count keeps every grant pattern reachable: home-port exhaustion, rebuilt reads, write stalls caused by a missing partner-bank port, and reads of registers that are being written in the same cycle.

// File: rtl/crf_pkg.sv
`timescale 1ns/1ps
package crf_pkg;

   typedef enum logic [1:0] {
      PATH_NONE    = 2'd0,
      PATH_DIRECT  = 2'd1,
      PATH_REBUILD = 2'd2
   } rd_path_e;

   function automatic logic other_bank(input logic b);
      return ~b;
   endfunction

endpackage

// File: rtl/crf_bank.sv
`timescale 1ns/1ps
module crf_bank #(
   parameter int ROWS = 64,
   parameter int DW   = 32,
   parameter int NRP  = 12,
   parameter int NWP  = 4,
   localparam int RW  = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NWP-1:0]    we,
   input  logic [NWP*RW-1:0] wrow,
   input  logic [NWP*DW-1:0] wdata,
   input  logic [NRP*RW-1:0] rrow,
   output logic [NRP*DW-1:0] rdata,
   output logic [ROWS*DW-1:0] image
);

   logic [DW-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < ROWS; r++) mem[r] <= '0;
      end else begin
         for (int w = 0; w < NWP; w++)
            if (we[w]) mem[wrow[w*RW +: RW]] <= wdata[w*DW +: DW];
      end
   end

   for (genvar p = 0; p < NRP; p++) begin : g_rport
      assign rdata[p*DW +: DW] = mem[rrow[p*RW +: RW]];
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_image
      assign image[r*DW +: DW] = mem[r];
   end

endmodule

// File: rtl/crf_alloc.sv
`timescale 1ns/1ps
module crf_alloc
   import crf_pkg::*;
#(
   parameter int NRD = 8,
   parameter int NWR = 4,
   parameter int BRD = 4,
   parameter int BWR = 2,
   parameter int CRD = 4,
   parameter int AW  = 7
) (
   input  logic [NRD-1:0]    rd_valid,
   input  logic [NRD*AW-1:0] rd_addr,
   input  logic [NWR-1:0]    wr_valid,
   input  logic [NWR*AW-1:0] wr_addr,
   output logic [NRD-1:0]    rd_gnt,
   output logic [NRD-1:0]    rd_rebuild,
   output logic [NWR-1:0]    wr_gnt
);

   rd_path_e path [NRD];

   // writes first: each one takes a home write port and a partner read port
   always_comb begin
      int   rfree [2];
      int   wfree [2];
      int   cfree;
      logic hb;
      logic dup;
      rfree[0] = BRD; rfree[1] = BRD;
      wfree[0] = BWR; wfree[1] = BWR;
      cfree    = CRD;
      wr_gnt   = '0;
      for (int w = 0; w < NWR; w++) begin
         hb  = wr_addr[w*AW];
         dup = 1'b0;
         for (int j = 0; j < w; j++)
            if (wr_gnt[j] && wr_addr[j*AW +: AW] == wr_addr[w*AW +: AW]) dup = 1'b1;
         if (wr_valid[w] && !dup && wfree[hb] > 0 && rfree[other_bank(hb)] > 0) begin
            wr_gnt[w]              = 1'b1;
            wfree[hb]              = wfree[hb] - 1;
            rfree[other_bank(hb)]  = rfree[other_bank(hb)] - 1;
         end
      end
      for (int i = 0; i < NRD; i++) begin
         hb      = rd_addr[i*AW];
         path[i] = PATH_NONE;
         if (rd_valid[i]) begin
            if (rfree[hb] > 0) begin
               path[i]   = PATH_DIRECT;
               rfree[hb] = rfree[hb] - 1;
            end else if (rfree[other_bank(hb)] > 0 && cfree > 0) begin
               path[i]               = PATH_REBUILD;
               rfree[other_bank(hb)] = rfree[other_bank(hb)] - 1;
               cfree                 = cfree - 1;
            end
         end
      end
   end

   for (genvar i = 0; i < NRD; i++) begin : g_path
      assign rd_gnt[i]     = (path[i] != PATH_NONE);
      assign rd_rebuild[i] = (path[i] == PATH_REBUILD);
   end

endmodule

// File: rtl/crf_top.sv
`timescale 1ns/1ps
module crf_top #(
   parameter int NREG = 128,
   parameter int DW   = 32,
   parameter int NRD  = 8,
   parameter int NWR  = 4,
   parameter int BRD  = 4,
   parameter int BWR  = 2,
   parameter int CRD  = 4,
   localparam int AW  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NRD-1:0]    rd_valid,
   input  logic [NRD*AW-1:0] rd_addr,
   output logic [NRD-1:0]    rd_ready,
   output logic [NRD*DW-1:0] rd_data,
   input  logic [NWR-1:0]    wr_valid,
   input  logic [NWR*AW-1:0] wr_addr,
   input  logic [NWR*DW-1:0] wr_data,
   output logic [NWR-1:0]    wr_ready
);

   localparam int ROWS = NREG / 2;
   localparam int RW   = AW - 1;
   localparam int NDP  = NRD + NWR;

   if (NREG < 4 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("crf_top: NREG must be a power of two of at least 4");
   end
   if (BRD < 1 || BWR < 1 || CRD < 1) begin : g_bad_ports
      $error("crf_top: every bank needs at least one port of each kind");
   end
   if (NWR > 2 * BWR) begin : g_bad_wr
      $error("crf_top: more logical write ports than bank write ports");
   end

   logic [NRD-1:0]     rd_gnt, rd_rebuild;
   logic [NWR-1:0]     wr_gnt;
   logic [NDP*RW-1:0]  d_rrow;
   logic [NDP*DW-1:0]  a_rd, b_rd;
   logic [NRD*DW-1:0]  c_rd;
   logic [NWR*RW-1:0]  w_row;
   logic [NWR-1:0]     we_a, we_b;
   logic [NWR*DW-1:0]  c_wdata;
   logic [ROWS*DW-1:0] a_img, b_img, c_img;

   crf_alloc #(.NRD(NRD), .NWR(NWR), .BRD(BRD), .BWR(BWR), .CRD(CRD), .AW(AW)) u_alloc (
      .rd_valid(rd_valid), .rd_addr(rd_addr), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .rd_gnt(rd_gnt), .rd_rebuild(rd_rebuild), .wr_gnt(wr_gnt));

   assign rd_ready = rd_gnt;
   assign wr_ready = wr_gnt;

   for (genvar i = 0; i < NRD; i++) begin : g_rd
      logic          hb;
      logic [DW-1:0] va, vb, vc;
      assign hb                = rd_addr[i*AW];
      assign d_rrow[i*RW +: RW] = rd_addr[i*AW+1 +: RW];
      assign va                = a_rd[i*DW +: DW];
      assign vb                = b_rd[i*DW +: DW];
      assign vc                = c_rd[i*DW +: DW];
      assign rd_data[i*DW +: DW] = rd_rebuild[i] ? ((hb ? va : vb) ^ vc) : (hb ? vb : va);
   end

   for (genvar w = 0; w < NWR; w++) begin : g_wr
      assign w_row[w*RW +: RW]         = wr_addr[w*AW+1 +: RW];
      assign d_rrow[(NRD+w)*RW +: RW]  = wr_addr[w*AW+1 +: RW];
      assign we_a[w]                   = wr_gnt[w] & ~wr_addr[w*AW];
      assign we_b[w]                   = wr_gnt[w] &  wr_addr[w*AW];
   end

   // coded row = new value XOR partner (new partner value if also written now)
   always_comb begin
      logic [DW-1:0] partner;
      for (int w = 0; w < NWR; w++) begin
         partner = wr_addr[w*AW] ? a_rd[(NRD+w)*DW +: DW] : b_rd[(NRD+w)*DW +: DW];
         for (int j = 0; j < NWR; j++)
            if (wr_gnt[j] && wr_addr[j*AW +: AW] == (wr_addr[w*AW +: AW] ^ AW'(1)))
               partner = wr_data[j*DW +: DW];
         c_wdata[w*DW +: DW] = wr_data[w*DW +: DW] ^ partner;
      end
   end

   crf_bank #(.ROWS(ROWS), .DW(DW), .NRP(NDP), .NWP(NWR)) u_bank_a (
      .clk(clk), .rst(rst), .we(we_a), .wrow(w_row), .wdata(wr_data),
      .rrow(d_rrow), .rdata(a_rd), .image(a_img));

   crf_bank #(.ROWS(ROWS), .DW(DW), .NRP(NDP), .NWP(NWR)) u_bank_b (
      .clk(clk), .rst(rst), .we(we_b), .wrow(w_row), .wdata(wr_data),
      .rrow(d_rrow), .rdata(b_rd), .image(b_img));

   crf_bank #(.ROWS(ROWS), .DW(DW), .NRP(NRD), .NWP(NWR)) u_bank_c (
      .clk(clk), .rst(rst), .we(wr_gnt), .wrow(w_row), .wdata(c_wdata),
      .rrow(d_rrow[NRD*RW-1:0]), .rdata(c_rd), .image(c_img));

endmodule

// File: rtl/crf_check.sv
`timescale 1ns/1ps
module crf_check #(
   parameter int NREG = 128,
   parameter int DW   = 32,
   parameter int NRD  = 8,
   parameter int NWR  = 4,
   parameter int BRD  = 4,
   parameter int BWR  = 2,
   localparam int AW  = $clog2(NREG),
   localparam int ROWS = NREG / 2
) (
   input logic               clk,
   input logic               rst,
   input logic [NRD-1:0]     rd_valid,
   input logic [NRD*AW-1:0]  rd_addr,
   input logic [NRD-1:0]     rd_ready,
   input logic [NWR-1:0]     wr_valid,
   input logic [NWR*AW-1:0]  wr_addr,
   input logic [NWR-1:0]     wr_ready,
   input logic [ROWS*DW-1:0] a_img,
   input logic [ROWS*DW-1:0] b_img,
   input logic [ROWS*DW-1:0] c_img
);

   logic incoherent, nonzero, order_bad, dup_bad;
   logic [NWR-1:0] wg_a, wg_b;
   logic [NRD-1:0] rg;
   logic [NWR-1:0] wg;

   always_comb begin
      incoherent = 1'b0;
      nonzero    = 1'b0;
      for (int r = 0; r < ROWS; r++) begin
         if ((a_img[r*DW +: DW] ^ b_img[r*DW +: DW]) != c_img[r*DW +: DW]) incoherent = 1'b1;
         if ((a_img[r*DW +: DW] | b_img[r*DW +: DW] | c_img[r*DW +: DW]) != '0) nonzero = 1'b1;
      end
   end

   always_comb begin
      order_bad = 1'b0;
      dup_bad   = 1'b0;
      for (int i = 0; i < NRD; i++)
         for (int j = i + 1; j < NRD; j++)
            if (rd_valid[i] && !rd_ready[i] && rd_valid[j] && rd_ready[j] &&
                rd_addr[i*AW] == rd_addr[j*AW]) order_bad = 1'b1;
      for (int i = 0; i < NWR; i++)
         for (int j = i + 1; j < NWR; j++)
            if (wg[i] && wg[j] && wr_addr[i*AW +: AW] == wr_addr[j*AW +: AW]) dup_bad = 1'b1;
   end

   assign rg = rd_valid & rd_ready;
   assign wg = wr_valid & wr_ready;
   for (genvar w = 0; w < NWR; w++) begin : g_wg
      assign wg_a[w] = wg[w] & ~wr_addr[w*AW];
      assign wg_b[w] = wg[w] &  wr_addr[w*AW];
   end

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !nonzero);

   p_coded_coherent_r8: assert property (@(posedge clk) disable iff (rst)
      !incoherent);

   p_write_ports_r3: assert property (@(posedge clk) disable iff (rst)
      ($countones(wg_a) <= BWR) && ($countones(wg_b) <= BWR));

   p_single_writer_r4: assert property (@(posedge clk) disable iff (rst)
      !dup_bad);

   p_read_order_r5: assert property (@(posedge clk) disable iff (rst)
      !order_bad);

   p_port_budget_r6: assert property (@(posedge clk) disable iff (rst)
      $countones({rg, wg}) <= 2 * BRD);

endmodule

bind crf_top crf_check #(
   .NREG(NREG), .DW(DW), .NRD(NRD), .NWR(NWR), .BRD(BRD), .BWR(BWR)
) u_check (
   .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
   .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_ready(wr_ready),
   .a_img(a_img), .b_img(b_img), .c_img(c_img)
);

// File: tb/crf_top_bench.sv
`timescale 1ns/1ps
module crf_top_bench;

   localparam int NREG = 16;
   localparam int DW   = 8;
   localparam int NRD  = 8;
   localparam int NWR  = 4;
   localparam int BRD  = 4;
   localparam int BWR  = 2;
   localparam int CRD  = 4;
   localparam int AW   = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst;
   logic [NRD-1:0]    rd_valid, rd_ready;
   logic [NRD*AW-1:0] rd_addr;
   logic [NRD*DW-1:0] rd_data;
   logic [NWR-1:0]    wr_valid, wr_ready;
   logic [NWR*AW-1:0] wr_addr;
   logic [NWR*DW-1:0] wr_data;

   logic [AW-1:0] ra [NRD];
   logic [AW-1:0] wa [NWR];
   logic [DW-1:0] wd [NWR];
   logic [DW-1:0] refm [NREG];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always_comb begin
      for (int i = 0; i < NRD; i++) rd_addr[i*AW +: AW] = ra[i];
      for (int w = 0; w < NWR; w++) begin
         wr_addr[w*AW +: AW] = wa[w];
         wr_data[w*DW +: DW] = wd[w];
      end
   end

   crf_top #(.NREG(NREG), .DW(DW), .NRD(NRD), .NWR(NWR), .BRD(BRD), .BWR(BWR), .CRD(CRD))
   u_crf_top (
      .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
      .rd_data(rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_ready(wr_ready));

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // grant model written from the requirements
   task automatic model(output logic [NRD-1:0] er, output logic [NWR-1:0] ew);
      int rf [2];
      int wf [2];
      int cf;
      rf[0] = BRD; rf[1] = BRD; wf[0] = BWR; wf[1] = BWR; cf = CRD;
      er = '0; ew = '0;
      for (int w = 0; w < NWR; w++) begin
         int  b;
         bit  dup;
         b   = int'(wa[w][0]);
         dup = 1'b0;
         for (int j = 0; j < w; j++) if (ew[j] && wa[j] == wa[w]) dup = 1'b1;
         if (wr_valid[w] && !dup && wf[b] > 0 && rf[1-b] > 0) begin
            ew[w] = 1'b1; wf[b]--; rf[1-b]--;
         end
      end
      for (int i = 0; i < NRD; i++) begin
         int b;
         b = int'(ra[i][0]);
         if (rd_valid[i]) begin
            if (rf[b] > 0) begin
               er[i] = 1'b1; rf[b]--;
            end else if (rf[1-b] > 0 && cf > 0) begin
               er[i] = 1'b1; rf[1-b]--; cf--;
            end
         end
      end
   endtask

   task automatic idle();
      rd_valid = '0; wr_valid = '0;
      for (int i = 0; i < NRD; i++) ra[i] = '0;
      for (int w = 0; w < NWR; w++) begin wa[w] = '0; wd[w] = '0; end
   endtask

   // inputs are set just after a falling edge; sample, then commit at the rising edge
   task automatic step(input string tag);
      logic [NRD-1:0] er;
      logic [NWR-1:0] ew;
      #2;
      model(er, ew);
      chk(rd_ready == er, tag, "rd_ready", 32'(rd_ready), 32'(er));
      chk(wr_ready == ew, tag, "wr_ready", 32'(wr_ready), 32'(ew));
      for (int i = 0; i < NRD; i++)
         if (er[i] && rd_ready[i])
            chk(rd_data[i*DW +: DW] == refm[ra[i]], tag, "rd_data",
                32'(rd_data[i*DW +: DW]), 32'(refm[ra[i]]));
      @(posedge clk);
      #1;
      for (int w = 0; w < NWR; w++) if (ew[w]) refm[wa[w]] = wd[w];
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      idle();
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      for (int r = 0; r < NREG; r++) refm[r] = '0;
      @(negedge clk);
   endtask

   task automatic read_all(input string tag);
      for (int h = 0; h < NREG / NRD; h++) begin
         idle();
         rd_valid = '1;
         for (int i = 0; i < NRD; i++) ra[i] = AW'(h * NRD + i);
         step(tag);
      end
   endtask

   initial begin
      #(20 * 200000);
      chk(1'b0, "watchdog", "timeout", 32'(0), 32'(1));
      if (!done) $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst = 1'b1;
      idle();
      do_reset();

      // R1: all registers read back as zero after reset
      read_all("R1");

      // R2 R3: sweep writes over every register, two per bank per cycle
      for (int pass = 0; pass < 3; pass++) begin
         for (int base = 0; base < NREG; base += NWR) begin
            idle();
            wr_valid = '1;
            for (int w = 0; w < NWR; w++) begin
               wa[w] = AW'(base + w);
               wd[w] = DW'((base + w) * 37 + pass * 11 + 5);
            end
            rd_valid = 8'h0F;
            for (int i = 0; i < NRD; i++) ra[i] = AW'((base + 7 * i) % NREG);
            step("R2 R3");
         end
         read_all("R2");
      end

      // R6: eight reads into bank A, no writes: four direct, four rebuilt
      idle();
      rd_valid = '1;
      for (int i = 0; i < NRD; i++) ra[i] = AW'(2 * i % NREG);
      #2 chk(rd_ready == 8'hFF, "R6", "rebuild mask", 32'(rd_ready), 32'hFF);
      step("R6");

      // R3 R6: two bank-A writes eat two bank-B read ports, reads 6 and 7 stall
      idle();
      rd_valid = '1;
      for (int i = 0; i < NRD; i++) ra[i] = AW'(2 * i % NREG);
      wr_valid = 4'b0011; wa[0] = 4'd10; wd[0] = 8'hA1; wa[1] = 4'd12; wd[1] = 8'hB2;
      #2 chk(rd_ready == 8'h3F, "R6", "stall mask", 32'(rd_ready), 32'h3F);
      step("R3 R6");

      // R7: read register 0 on all ports while writing it; old value on direct and rebuilt
      idle();
      rd_valid = '1;
      wr_valid = 4'b0001; wa[0] = 4'd0; wd[0] = 8'h5C;
      #2 chk(rd_ready == 8'h7F, "R7", "mask", 32'(rd_ready), 32'h7F);
      step("R7");
      idle(); rd_valid = 8'h01; ra[0] = 4'd0;
      #2 chk(rd_data[DW-1:0] == 8'h5C, "R7", "new value next cycle", 32'(rd_data[DW-1:0]), 32'h5C);
      step("R7");

      // R4 R10: duplicate address, and a third bank-A write with no port left
      idle();
      wr_valid = 4'b1111;
      wa[0] = 4'd2; wd[0] = 8'h11;
      wa[1] = 4'd2; wd[1] = 8'h22;
      wa[2] = 4'd4; wd[2] = 8'h33;
      wa[3] = 4'd6; wd[3] = 8'h44;
      #2 chk(wr_ready == 4'b0101, "R4 R10", "write mask", 32'(wr_ready), 32'h5);
      step("R4 R10");
      idle(); rd_valid = 8'h07; ra[0] = 4'd2; ra[1] = 4'd4; ra[2] = 4'd6;
      step("R4 R10");

      // R9: both banks write row 4, then rebuilt reads of both registers
      idle();
      wr_valid = 4'b0011; wa[0] = 4'd8; wd[0] = 8'h96; wa[1] = 4'd9; wd[1] = 8'h3D;
      step("R9");
      idle(); rd_valid = '1;
      for (int i = 0; i < NRD; i++) ra[i] = 4'd8;
      step("R9");
      idle(); rd_valid = '1;
      for (int i = 0; i < NRD; i++) ra[i] = 4'd9;
      step("R9");

      // R2 R5 R6 R7 R9 R10: random traffic over every port
      for (int c = 0; c < 3000; c++) begin
         idle();
         rd_valid = NRD'($urandom);
         wr_valid = NWR'($urandom);
         for (int i = 0; i < NRD; i++) ra[i] = AW'($urandom);
         for (int w = 0; w < NWR; w++) begin
            wa[w] = AW'($urandom);
            wd[w] = DW'($urandom);
         end
         step("R2 R5 R6 R7");
      end

      // R1: a second reset after traffic clears everything again
      do_reset();
      read_all("R1");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule